// File: doc/BRIEF.md
# CAN Operating Mode Controller

This block holds the operating mode of a CAN controller. It also decides, for each mode, how the transmit and receive paths run between the protocol engine and the external transceiver pins. Software writes a one-hot mode request. The block checks that the code is legal and queues it. It applies the request when the bus is idle, except for a return to configuration mode, which always takes effect on the next clock edge.

From the current mode the block derives several outputs:
- the level on the transceiver TX pin;
- the RX bit that the engine sees, which is either the external pin or an internal loop from the engine's own TX bit;
- a transmit grant, formed from the pending flags of the TX FIFO and the high-priority buffer;
- a receive enable, a self-acknowledge flag and the error-counter reset.

While asleep, a completed frame from the bus wakes the controller into normal mode. Sleep entry and wake-up each raise a one-cycle interrupt pulse.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset the mode output is 0x01 (configuration), both interrupt pulses are low, the TX pin is 1 and the error-counter reset is high.
- R2: Mode codes on `mode_req` and `mode_q` are one-hot: 0x01 configuration, 0x02 normal, 0x04 loopback, 0x08 sleep, 0x10 snoop. A request with zero or several bits set is ignored and leaves both the mode and any queued request unchanged.
- R3: A legal request for 0x01 sets the mode to configuration at the next clock edge, whatever the bus state is, and discards any queued request.
- R4: Any other legal request is queued, replacing an older queued one. It is applied at the first later edge where `bus_idle` is 1, or at the next edge if the current mode is configuration.
- R5: In configuration mode `pin_tx`=1, `eng_rx`=1, `tx_grant`=0, `rx_en`=0, `self_ack`=0 and `err_cnt_rst`=1. `err_cnt_rst` is 0 in every other mode.
- R6: In normal mode `pin_tx` follows `eng_tx`, `eng_rx` follows `pin_rx`, `tx_grant` = `tx_fifo_pend` OR `tx_hpb_pend`, and `rx_en`=1.
- R7: In loopback mode `pin_tx`=1, `eng_rx` follows `eng_tx` (so `pin_rx` has no effect), `self_ack`=1, `tx_grant` is the OR of the pending flags, and `rx_en`=1.
- R8: In snoop mode `pin_tx`=1, `tx_grant`=0, `eng_rx` follows `pin_rx` and `rx_en`=1.
- R9: In sleep mode `tx_grant`=0 even when transmit requests are pending, `pin_tx`=1, `eng_rx` follows `pin_rx` and `rx_en`=1.
- R10: With `rx_frame_done`=1 in sleep mode and no configuration request, the next edge sets the mode to normal. It also raises `irq_wake` for exactly that one cycle and discards a queued request or a non-configuration request made in the same cycle.
- R11: `irq_sleep` is high for exactly one cycle: the first cycle in which the mode is sleep after a different mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req_valid | input | 1 | Mode request strobe |
| mode_req | input | 5 | Requested one-hot mode code |
| bus_idle | input | 1 | Bus is at a frame boundary |
| tx_fifo_pend | input | 1 | TX FIFO holds a frame to send |
| tx_hpb_pend | input | 1 | High-priority buffer holds a frame |
| rx_frame_done | input | 1 | A frame was received from the bus |
| eng_tx | input | 1 | TX bit from the protocol engine |
| pin_rx | input | 1 | RX bit from the transceiver |
| pin_tx | output | 1 | TX bit to the transceiver (1 = recessive) |
| eng_rx | output | 1 | RX bit presented to the engine |
| tx_grant | output | 1 | Engine may start a transmission |
| rx_en | output | 1 | Engine may store received frames |
| self_ack | output | 1 | Engine acknowledges its own frames |
| err_cnt_rst | output | 1 | Hold error counters in reset |
| mode_q | output | 5 | Current one-hot mode |
| irq_sleep | output | 1 | Sleep-entry pulse |
| irq_wake | output | 1 | Wake-up pulse |

## Verification
The hardest state to reach from the ports is a conflict in which a request is queued behind a busy bus while another event arrives before it can apply. That event can be a wake-up frame, a newer request or a configuration request. The bench holds `bus_idle` low while it stacks requests, and fires `rx_frame_done` or a 0x01 request in that window. A long random phase with rare idle slots and frames then mixes these cases against the reference model on every clock.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    localparam int MODE_W = 5;

    typedef enum logic [MODE_W-1:0] {
        OPM_CFG   = 5'h01,
        OPM_RUN   = 5'h02,
        OPM_LOOP  = 5'h04,
        OPM_SLEEP = 5'h08,
        OPM_SNOOP = 5'h10
    } opmode_e;

    typedef struct packed {
        opmode_e mode;
        logic    pend_v;
        opmode_e pend_mode;
        logic    irq_sleep;
        logic    irq_wake;
    } mode_state_t;

    typedef struct packed {
        logic pin_tx;
        logic eng_rx;
        logic tx_grant;
        logic rx_en;
        logic self_ack;
        logic err_cnt_rst;
    } steer_t;

endpackage

// File: rtl/cmc_req_filter.sv
module cmc_req_filter
    import can_mode_pkg::*;
(
    input  logic              req_valid,
    input  logic [MODE_W-1:0] req_code,
    output logic              req_legal,
    output logic              req_cfg
);
    logic one_bit;

    always_comb begin
        one_bit   = ($countones(req_code) == 1);
        req_legal = req_valid && one_bit;
        req_cfg   = req_legal && (req_code == OPM_CFG);
    end
endmodule

// File: rtl/cmc_mode_fsm.sv
module cmc_mode_fsm
    import can_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_legal,
    input  logic              req_cfg,
    input  logic [MODE_W-1:0] req_code,
    input  logic              bus_idle,
    input  logic              rx_frame_done,
    output opmode_e           mode,
    output logic              irq_sleep,
    output logic              irq_wake
);
    mode_state_t st_d, st_q;
    logic        wake_hit;
    logic        apply_ok;

    always_comb begin
        st_d           = st_q;
        st_d.irq_sleep = 1'b0;
        st_d.irq_wake  = 1'b0;
        wake_hit       = (st_q.mode == OPM_SLEEP) && rx_frame_done;
        apply_ok       = st_q.pend_v && (bus_idle || st_q.mode == OPM_CFG);

        if (req_cfg) begin
            st_d.mode   = OPM_CFG;
            st_d.pend_v = 1'b0;
        end else if (wake_hit) begin
            st_d.mode     = OPM_RUN;
            st_d.pend_v   = 1'b0;
            st_d.irq_wake = 1'b1;
        end else if (req_legal) begin
            st_d.pend_v    = 1'b1;
            st_d.pend_mode = opmode_e'(req_code);
        end else if (apply_ok) begin
            st_d.mode   = st_q.pend_mode;
            st_d.pend_v = 1'b0;
        end

        st_d.irq_sleep = (st_d.mode == OPM_SLEEP) && (st_q.mode != OPM_SLEEP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode      <= OPM_CFG;
            st_q.pend_v    <= 1'b0;
            st_q.pend_mode <= OPM_CFG;
            st_q.irq_sleep <= 1'b0;
            st_q.irq_wake  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode      = st_q.mode;
    assign irq_sleep = st_q.irq_sleep;
    assign irq_wake  = st_q.irq_wake;
endmodule

// File: rtl/cmc_pin_steer.sv
module cmc_pin_steer
    import can_mode_pkg::*;
(
    input  opmode_e mode,
    input  logic    eng_tx,
    input  logic    pin_rx,
    input  logic    tx_pend,
    output steer_t  steer
);
    always_comb begin
        steer.pin_tx      = 1'b1;
        steer.eng_rx      = 1'b1;
        steer.tx_grant    = 1'b0;
        steer.rx_en       = 1'b0;
        steer.self_ack    = 1'b0;
        steer.err_cnt_rst = 1'b0;
        unique case (mode)
            OPM_RUN: begin
                steer.pin_tx   = eng_tx;
                steer.eng_rx   = pin_rx;
                steer.tx_grant = tx_pend;
                steer.rx_en    = 1'b1;
            end
            OPM_LOOP: begin
                steer.eng_rx   = eng_tx;
                steer.tx_grant = tx_pend;
                steer.rx_en    = 1'b1;
                steer.self_ack = 1'b1;
            end
            OPM_SLEEP, OPM_SNOOP: begin
                steer.eng_rx = pin_rx;
                steer.rx_en  = 1'b1;
            end
            default: begin
                steer.err_cnt_rst = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
    import can_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_req_valid,
    input  logic [MODE_W-1:0] mode_req,
    input  logic              bus_idle,
    input  logic              tx_fifo_pend,
    input  logic              tx_hpb_pend,
    input  logic              rx_frame_done,
    input  logic              eng_tx,
    input  logic              pin_rx,
    output logic              pin_tx,
    output logic              eng_rx,
    output logic              tx_grant,
    output logic              rx_en,
    output logic              self_ack,
    output logic              err_cnt_rst,
    output logic [MODE_W-1:0] mode_q,
    output logic              irq_sleep,
    output logic              irq_wake
);
    logic    req_legal;
    logic    req_cfg;
    opmode_e cur_mode;
    steer_t  steer;

    cmc_req_filter u_filt (
        .req_valid (mode_req_valid),
        .req_code  (mode_req),
        .req_legal (req_legal),
        .req_cfg   (req_cfg)
    );

    cmc_mode_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_legal     (req_legal),
        .req_cfg       (req_cfg),
        .req_code      (mode_req),
        .bus_idle      (bus_idle),
        .rx_frame_done (rx_frame_done),
        .mode          (cur_mode),
        .irq_sleep     (irq_sleep),
        .irq_wake      (irq_wake)
    );

    cmc_pin_steer u_steer (
        .mode    (cur_mode),
        .eng_tx  (eng_tx),
        .pin_rx  (pin_rx),
        .tx_pend (tx_fifo_pend | tx_hpb_pend),
        .steer   (steer)
    );

    assign mode_q      = cur_mode;
    assign pin_tx      = steer.pin_tx;
    assign eng_rx      = steer.eng_rx;
    assign tx_grant    = steer.tx_grant;
    assign rx_en       = steer.rx_en;
    assign self_ack    = steer.self_ack;
    assign err_cnt_rst = steer.err_cnt_rst;
endmodule

// File: rtl/can_mode_ctrl_chk.sv
module can_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_req_valid,
    input logic [4:0] mode_req,
    input logic       bus_idle,
    input logic       rx_frame_done,
    input logic       eng_tx,
    input logic       pin_tx,
    input logic       eng_rx,
    input logic       tx_grant,
    input logic       err_cnt_rst,
    input logic [4:0] mode_q,
    input logic       irq_sleep,
    input logic       irq_wake
);
    logic cfg_req;
    assign cfg_req = mode_req_valid && (mode_req == 5'h01);

    AST_MODE_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mode_q) == 1); // R2

    AST_CFG_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |=> (mode_q == 5'h01)); // R3

    AST_HOLD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != 5'h01 && !bus_idle && !cfg_req && !(mode_q == 5'h08 && rx_frame_done))
        |=> $stable(mode_q)); // R4

    AST_CFG_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 5'h01) |-> (pin_tx && err_cnt_rst && !tx_grant)); // R5

    AST_LOOP_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 5'h04) |-> (pin_tx && eng_rx == eng_tx)); // R7

    AST_SLEEP_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 5'h08) |-> !tx_grant); // R9

    AST_WAKE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 5'h08 && rx_frame_done && !cfg_req) |=> (mode_q == 5'h02 && irq_wake)); // R10

    AST_SLEEP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_sleep |-> (mode_q == 5'h08 && $past(mode_q) != 5'h08)); // R11
endmodule

bind can_mode_ctrl can_mode_ctrl_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_req_valid (mode_req_valid),
    .mode_req       (mode_req),
    .bus_idle       (bus_idle),
    .rx_frame_done  (rx_frame_done),
    .eng_tx         (eng_tx),
    .pin_tx         (pin_tx),
    .eng_rx         (eng_rx),
    .tx_grant       (tx_grant),
    .err_cnt_rst    (err_cnt_rst),
    .mode_q         (mode_q),
    .irq_sleep      (irq_sleep),
    .irq_wake       (irq_wake)
);

// File: tb/sim_can_mode_ctrl.sv
module sim_can_mode_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_req_valid = 1'b0;
    logic [4:0] mode_req = 5'h00;
    logic bus_idle = 1'b1;
    logic tx_fifo_pend = 1'b0;
    logic tx_hpb_pend = 1'b0;
    logic rx_frame_done = 1'b0;
    logic eng_tx = 1'b1;
    logic pin_rx = 1'b1;
    logic pin_tx, eng_rx, tx_grant, rx_en, self_ack, err_cnt_rst, irq_sleep, irq_wake;
    logic [4:0] mode_q;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference model state
    int m_mode = 1;
    bit m_pv = 0;
    int m_pd = 1;
    bit m_isl = 0;
    bit m_iwk = 0;

    always #2 clk = ~clk;

    can_mode_ctrl u0 (.*);

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        int  nm;
        bit  legal;
        legal = mode_req_valid && ($countones(mode_req) == 1);
        if (!rst_n) begin
            m_mode = 1; m_pv = 0; m_pd = 1; m_isl = 0; m_iwk = 0;
            return;
        end
        nm = m_mode;
        m_iwk = 0;
        if (legal && mode_req == 5'h01) begin
            nm = 1; m_pv = 0;
        end else if (m_mode == 8 && rx_frame_done) begin
            nm = 2; m_pv = 0; m_iwk = 1;
        end else if (legal) begin
            m_pv = 1; m_pd = int'(mode_req);
        end else if (m_pv && (bus_idle || m_mode == 1)) begin
            nm = m_pd; m_pv = 0;
        end
        m_isl = (nm == 8) && (m_mode != 8);
        m_mode = nm;
    endtask

    task automatic compare_all();
        int    pend;
        int    e_ptx, e_erx, e_g, e_rxen, e_sa, e_ecr;
        string tg;
        pend = int'(tx_fifo_pend | tx_hpb_pend);
        e_ptx = 1; e_erx = 1; e_g = 0; e_rxen = 0; e_sa = 0; e_ecr = 0;
        case (m_mode)
            2: begin tg = "R6"; e_ptx = int'(eng_tx); e_erx = int'(pin_rx); e_g = pend; e_rxen = 1; end
            4: begin tg = "R7"; e_erx = int'(eng_tx); e_g = pend; e_rxen = 1; e_sa = 1; end
            8: begin tg = "R9"; e_erx = int'(pin_rx); e_rxen = 1; end
            16: begin tg = "R8"; e_erx = int'(pin_rx); e_rxen = 1; end
            default: begin tg = "R5"; e_ecr = 1; end
        endcase
        chk("R4 mode", int'(mode_q), m_mode);
        chk({tg, " pin_tx"}, int'(pin_tx), e_ptx);
        chk({tg, " eng_rx"}, int'(eng_rx), e_erx);
        chk({tg, " tx_grant"}, int'(tx_grant), e_g);
        chk({tg, " rx_en"}, int'(rx_en), e_rxen);
        chk({tg, " self_ack"}, int'(self_ack), e_sa);
        chk({tg, " err_cnt_rst"}, int'(err_cnt_rst), e_ecr);
        chk("R11 irq_sleep", int'(irq_sleep), int'(m_isl));
        chk("R10 irq_wake", int'(irq_wake), int'(m_iwk));
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        compare_all();
    endtask

    task automatic request(logic [4:0] code);
        mode_req_valid = 1'b1;
        mode_req = code;
        step();
        mode_req_valid = 1'b0;
        mode_req = 5'h00;
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 mode", int'(mode_q), 1);
        chk("R1 pin_tx", int'(pin_tx), 1);
        chk("R1 err_cnt_rst", int'(err_cnt_rst), 1);
        chk("R1 irq", int'(irq_sleep | irq_wake), 0);

        // R2 illegal codes ignored
        request(5'h00); step();
        request(5'h03); step();
        request(5'h1F); step();
        chk("R2 illegal kept cfg", int'(mode_q), 1);

        // leave configuration at once even with a busy bus (R4)
        bus_idle = 1'b0;
        request(5'h02); step();
        chk("R4 leave cfg", int'(mode_q), 2);

        // R6 normal traffic
        tx_fifo_pend = 1'b1;
        for (int i = 0; i < 8; i++) begin
            eng_tx = i[0]; pin_rx = i[1]; step();
        end
        tx_fifo_pend = 1'b0; tx_hpb_pend = 1'b1; step();

        // R4 wait for idle, then loopback R7
        request(5'h04);
        repeat (4) step();
        chk("R4 held busy", int'(mode_q), 2);
        bus_idle = 1'b1; step();
        chk("R7 loopback", int'(mode_q), 4);
        for (int i = 0; i < 6; i++) begin
            eng_tx = i[0]; pin_rx = ~i[0]; step();
        end

        // R8 snoop
        request(5'h10); step();
        chk("R8 snoop", int'(mode_q), 16);
        for (int i = 0; i < 4; i++) begin
            pin_rx = i[0]; eng_tx = 1'b0; step();
        end

        // R11 sleep entry, R9 pending ignored
        mode_req_valid = 1'b1; mode_req = 5'h08; step();
        mode_req_valid = 1'b0; step();
        chk("R11 sleep pulse", int'(irq_sleep), 1);
        step();
        chk("R11 pulse ends", int'(irq_sleep), 0);
        tx_fifo_pend = 1'b1;
        repeat (3) step();
        chk("R9 no grant", int'(tx_grant), 0);

        // R10 wake while a request is queued behind a busy bus
        bus_idle = 1'b0;
        request(5'h10);
        rx_frame_done = 1'b1; step(); rx_frame_done = 1'b0;
        chk("R10 wake run", int'(mode_q), 2);
        chk("R10 wake pulse", int'(irq_wake), 1);
        bus_idle = 1'b1; step();
        chk("R10 queue dropped", int'(mode_q), 2);

        // R3 configuration overrides a queued request
        bus_idle = 1'b0;
        request(5'h04);
        request(5'h01);
        chk("R3 cfg now", int'(mode_q), 1);
        bus_idle = 1'b1; step(); step();
        chk("R3 queue dropped", int'(mode_q), 1);

        // R4 newer request replaces older
        request(5'h02); step();
        bus_idle = 1'b0;
        request(5'h04);
        request(5'h10);
        bus_idle = 1'b1; step();
        chk("R4 replaced", int'(mode_q), 16);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom_range(0, 15));
            mode_req_valid = (r < 3);
            mode_req = (r == 0) ? 5'($urandom) : (5'h01 << $urandom_range(0, 4));
            bus_idle = ($urandom_range(0, 3) == 0);
            rx_frame_done = ($urandom_range(0, 9) == 0);
            tx_fifo_pend = $urandom_range(0, 1) == 1;
            tx_hpb_pend = $urandom_range(0, 3) == 0;
            eng_tx = $urandom_range(0, 1) == 1;
            pin_rx = $urandom_range(0, 1) == 1;
            step();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule